// File: doc/BRIEF.md
# DRAM Refresh Scheduler

This block keeps a synchronous DRAM supplied with auto-refresh commands. A down-counter divides the system clock into refresh slots, by default a 64 ms retention window split into 4096 slots. Each slot that elapses adds one refresh to a small debt counter. The command controller sees a refresh request while that debt is non-zero and every bank is precharged. Each refresh-done acknowledge from the controller pays back one unit. When the debt reaches its ceiling, an urgent flag tells the controller to stop postponing.

The block also handles low-power operation. While a low-power request is held and all banks are closed, it issues a one-cycle self-refresh entry strobe and drops clock enable in that same cycle. It then keeps clock enable low for as long as the request stays high. When the request falls, it raises clock enable for one quiet cycle. It then requests a single catch-up auto refresh and holds off ordinary traffic until that refresh is acknowledged. The bank timing and the command encoding stay in the controller.

Top module: `dram_refresh_sched`

## Requirements
- R1: Outside self refresh, one refresh is added to `owed_cnt` every `INTERVAL` clocks. The first is added at the `INTERVAL`-th rising edge after reset is released. By default `INTERVAL` is computed as clock kHz × window ms / refresh rows (3125 at 200 MHz).
- R2: A `rf_ack` while `owed_cnt` is non-zero and no slot elapses lowers the count by one. A `rf_ack` while `owed_cnt` is zero leaves it at zero.
- R3: `owed_cnt` never exceeds `MAX_OWED` (8). A slot that elapses at the ceiling is dropped. `rf_urgent` is high exactly when `owed_cnt` equals `MAX_OWED`.
- R4: When a slot elapses in the same cycle as an acknowledge and the debt is non-zero, `owed_cnt` is unchanged. This also holds at the ceiling.
- R5: `rf_req` is high only when `owed_cnt` is non-zero and `banks_idle` is high, and only in normal mode with `lp_req` low or in the post-exit phase.
- R6: In normal mode, `sr_entry` is high in any cycle where `lp_req` and `banks_idle` are both high. In that cycle `cke` is low and `rf_req` is low. The following edge clears `owed_cnt` and enters self refresh. With `banks_idle` low, no entry happens.
- R7: In self refresh, `cke` stays low, no slots elapse, and `rf_ack` is ignored. The slot counter restarts from a full interval, so the first slot after exit elapses `INTERVAL` clocks after the exit edge.
- R8: The edge that samples `lp_req` low in self refresh starts a wake cycle. In that cycle `cke` is high, `rf_req` is low, `traffic_hold` is high and `owed_cnt` is 1.
- R9: After the wake cycle, the block requests the single catch-up refresh with `traffic_hold` high, and `lp_req` is ignored. The acknowledge returns it to normal mode with `traffic_hold` low.
- R10: While `rst` is high (sampled at the clock), the block returns to normal mode with `owed_cnt` 0, `cke` 1, `traffic_hold` 0 and no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| banks_idle | input | 1 | All banks are precharged |
| lp_req | input | 1 | Low-power (self refresh) request |
| rf_ack | input | 1 | Controller finished one auto refresh |
| rf_req | output | 1 | Request to issue an auto refresh |
| rf_urgent | output | 1 | Refresh debt at its ceiling |
| sr_entry | output | 1 | Issue self-refresh entry this cycle |
| cke | output | 1 | Clock-enable level for the DRAM |
| traffic_hold | output | 1 | Block normal traffic after self-refresh exit |
| owed_cnt | output | $clog2(MAX_OWED+1) | Refreshes currently owed |

## Verification
Two events can land in one cycle: the interval counter can expire on the same edge that an acknowledge arrives. The bench runs the clock to the edge where a slot is known to elapse and pulses the acknowledge for exactly that edge. It does this once with the debt at its ceiling and once with a debt of one. In both cases it expects the count to stay where it was, and one edge later it expects a plain acknowledge to decrement it. These expected counts follow from the slot timing in R1, because the counter restarts at reset and at self-refresh exit.

// File: rtl/rfsh_pkg.sv
package rfsh_pkg;

    typedef enum logic [1:0] {
        LP_RUN  = 2'd0,
        LP_SELF = 2'd1,
        LP_WAKE = 2'd2,
        LP_POST = 2'd3
    } lp_state_e;

    // Control bundle that steers the debt counter each cycle
    typedef struct packed {
        logic tick;   // a refresh slot elapsed
        logic ack;    // one refresh completed
        logic clear;  // self refresh entered: debt forgiven
        logic seed;   // self refresh left: one catch-up owed
    } bl_ctl_t;

    function automatic int unsigned refresh_interval(
        input int unsigned clk_khz,
        input int unsigned window_ms,
        input int unsigned rows
    );
        return (clk_khz * window_ms) / rows;
    endfunction

endpackage

// File: rtl/rfsh_interval.sv
module rfsh_interval #(
    parameter int unsigned INTERVAL = 3125
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic tick
);
    localparam int unsigned CW = (INTERVAL > 2) ? $clog2(INTERVAL) : 1;
    localparam logic [CW-1:0] RELOAD = CW'(INTERVAL - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !run)
            cnt <= RELOAD;
        else if (cnt == '0)
            cnt <= RELOAD;
        else
            cnt <= cnt - 1'b1;
    end

    assign tick = run && (cnt == '0);

    // R1
    reload_after_tick_chk: assert property (@(posedge clk) disable iff (rst)
        tick |=> (cnt == RELOAD));

    // R1
    count_range_chk: assert property (@(posedge clk) disable iff (rst)
        cnt <= RELOAD);

endmodule

// File: rtl/rfsh_backlog.sv
module rfsh_backlog
    import rfsh_pkg::*;
#(
    parameter int unsigned MAX_OWED = 8,
    parameter int unsigned OW       = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  bl_ctl_t       ctl,
    output logic [OW-1:0] owed,
    output logic          urgent
);
    localparam logic [OW-1:0] CEIL = OW'(MAX_OWED);

    logic full, empty;
    assign full  = (owed == CEIL);
    assign empty = (owed == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            owed <= '0;
        end else if (ctl.clear) begin
            owed <= '0;
        end else if (ctl.seed) begin
            owed <= OW'(1);
        end else begin
            unique case ({ctl.tick, ctl.ack})
                2'b10:   if (!full)  owed <= owed + 1'b1;
                2'b01:   if (!empty) owed <= owed - 1'b1;
                2'b11:   if (empty)  owed <= owed + 1'b1;
                default: owed <= owed;
            endcase
        end
    end

    assign urgent = full;

    // R3
    no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
        owed <= CEIL);

    // R4
    both_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (ctl.tick && ctl.ack && !ctl.clear && !ctl.seed && owed != '0)
        |=> (owed == $past(owed)));

    // R2
    ack_retire_chk: assert property (@(posedge clk) disable iff (rst)
        (ctl.ack && !ctl.tick && !ctl.clear && !ctl.seed && owed != '0)
        |=> (owed == $past(owed) - 1'b1));

endmodule

// File: rtl/rfsh_lp_fsm.sv
module rfsh_lp_fsm
    import rfsh_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      lp_req,
    input  logic      banks_idle,
    input  logic      ack,
    output lp_state_e state,
    output logic      sr_entry
);
    lp_state_e state_nx;

    assign sr_entry = (state == LP_RUN) && lp_req && banks_idle;

    always_comb begin
        state_nx = state;
        unique case (state)
            LP_RUN:  if (sr_entry) state_nx = LP_SELF;
            LP_SELF: if (!lp_req)  state_nx = LP_WAKE;
            LP_WAKE: state_nx = LP_POST;
            LP_POST: if (ack)      state_nx = LP_RUN;
            default: state_nx = LP_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= LP_RUN;
        else     state <= state_nx;
    end

    // R9
    post_waits_ack_chk: assert property (@(posedge clk) disable iff (rst)
        (state == LP_POST && !ack) |=> (state == LP_POST));

endmodule

// File: rtl/dram_refresh_sched.sv
module dram_refresh_sched
    import rfsh_pkg::*;
#(
    parameter int unsigned CLK_KHZ      = 200000,
    parameter int unsigned WINDOW_MS    = 64,
    parameter int unsigned REFRESH_ROWS = 4096,
    parameter int unsigned INTERVAL     = refresh_interval(CLK_KHZ, WINDOW_MS, REFRESH_ROWS),
    parameter int unsigned MAX_OWED     = 8
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          banks_idle,
    input  logic                          lp_req,
    input  logic                          rf_ack,
    output logic                          rf_req,
    output logic                          rf_urgent,
    output logic                          sr_entry,
    output logic                          cke,
    output logic                          traffic_hold,
    output logic [$clog2(MAX_OWED+1)-1:0] owed_cnt
);
    localparam int unsigned OW = $clog2(MAX_OWED + 1);

    lp_state_e state;
    logic      tick;
    logic      slot_run;
    bl_ctl_t   ctl;

    rfsh_lp_fsm u_fsm (
        .clk        (clk),
        .rst        (rst),
        .lp_req     (lp_req),
        .banks_idle (banks_idle),
        .ack        (rf_ack),
        .state      (state),
        .sr_entry   (sr_entry)
    );

    assign slot_run = (state != LP_SELF) && !sr_entry;

    rfsh_interval #(.INTERVAL(INTERVAL)) u_slot (
        .clk  (clk),
        .rst  (rst),
        .run  (slot_run),
        .tick (tick)
    );

    always_comb begin
        ctl.tick  = tick;
        ctl.ack   = rf_ack && ((state == LP_RUN) || (state == LP_POST));
        ctl.clear = sr_entry;
        ctl.seed  = (state == LP_SELF) && !lp_req;
    end

    rfsh_backlog #(.MAX_OWED(MAX_OWED), .OW(OW)) u_debt (
        .clk    (clk),
        .rst    (rst),
        .ctl    (ctl),
        .owed   (owed_cnt),
        .urgent (rf_urgent)
    );

    assign rf_req = (owed_cnt != '0) && banks_idle &&
                    (((state == LP_RUN) && !lp_req) || (state == LP_POST));

    assign cke          = !(sr_entry || (state == LP_SELF));
    assign traffic_hold = (state == LP_WAKE) || (state == LP_POST);

    // R5
    req_needs_debt_chk: assert property (@(posedge clk) disable iff (rst)
        rf_req |-> (owed_cnt != '0 && banks_idle && cke));

    // R6
    entry_sleeps_chk: assert property (@(posedge clk) disable iff (rst)
        sr_entry |=> (!cke && owed_cnt == '0));

    // R7
    no_tick_in_self_chk: assert property (@(posedge clk) disable iff (rst)
        (state == LP_SELF) |-> !tick);

    // R8
    wake_gap_chk: assert property (@(posedge clk) disable iff (rst)
        (state == LP_SELF && !lp_req) |=> (cke && !rf_req && owed_cnt == OW'(1)));

endmodule

// File: tb/dram_refresh_sched_bench.sv
`timescale 1ns/1ps
module dram_refresh_sched_bench;

    localparam int unsigned INTERVAL = 16;
    localparam int unsigned MAX_OWED = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic banks_idle = 1'b0;
    logic lp_req = 1'b0;
    logic rf_ack = 1'b0;
    logic rf_req, rf_urgent, sr_entry, cke, traffic_hold;
    logic [3:0] owed_cnt;

    always #2.5 clk = ~clk;

    dram_refresh_sched #(.INTERVAL(INTERVAL), .MAX_OWED(MAX_OWED)) u_dram_refresh_sched (
        .clk          (clk),
        .rst          (rst),
        .banks_idle   (banks_idle),
        .lp_req       (lp_req),
        .rf_ack       (rf_ack),
        .rf_req       (rf_req),
        .rf_urgent    (rf_urgent),
        .sr_entry     (sr_entry),
        .cke          (cke),
        .traffic_hold (traffic_hold),
        .owed_cnt     (owed_cnt)
    );

    typedef struct packed {
        logic        idle;
        logic        ack;   // applied for the first edge only
        logic        lp;
        logic [15:0] n;     // edges to run before sampling
        logic [3:0]  owed;
        logic        req;
        logic        urg;
        logic        sre;
        logic        cke;
        logic        hold;
        logic [3:0]  rq;    // requirement number
    } vec_t;

    localparam int NV = 23;
    localparam vec_t VEC [NV] = '{
        '{1'b0,1'b0,1'b0,16'd15, 4'd0,1'b0,1'b0,1'b0,1'b1,1'b0,4'd1},  // R1 edge15
        '{1'b0,1'b0,1'b0,16'd1,  4'd1,1'b0,1'b0,1'b0,1'b1,1'b0,4'd1},  // R1 edge16 slot
        '{1'b1,1'b0,1'b0,16'd0,  4'd1,1'b1,1'b0,1'b0,1'b1,1'b0,4'd5},  // R5 idle -> req
        '{1'b1,1'b1,1'b0,16'd1,  4'd0,1'b0,1'b0,1'b0,1'b1,1'b0,4'd2},  // R2 retire
        '{1'b1,1'b1,1'b0,16'd1,  4'd0,1'b0,1'b0,1'b0,1'b1,1'b0,4'd2},  // R2 ack at zero
        '{1'b0,1'b0,1'b0,16'd14, 4'd1,1'b0,1'b0,1'b0,1'b1,1'b0,4'd1},  // R1 edge32
        '{1'b0,1'b0,1'b0,16'd112,4'd8,1'b0,1'b1,1'b0,1'b1,1'b0,4'd3},  // R3 reach ceiling
        '{1'b0,1'b0,1'b0,16'd16, 4'd8,1'b0,1'b1,1'b0,1'b1,1'b0,4'd3},  // R3 saturate
        '{1'b1,1'b0,1'b0,16'd15, 4'd8,1'b1,1'b1,1'b0,1'b1,1'b0,4'd5},  // R5 edge175
        '{1'b1,1'b1,1'b0,16'd1,  4'd8,1'b1,1'b1,1'b0,1'b1,1'b0,4'd4},  // R4 slot+ack full
        '{1'b1,1'b1,1'b0,16'd1,  4'd7,1'b1,1'b0,1'b0,1'b1,1'b0,4'd2},  // R2
        '{1'b1,1'b1,1'b0,16'd1,  4'd6,1'b1,1'b0,1'b0,1'b1,1'b0,4'd2},  // R2
        '{1'b0,1'b0,1'b1,16'd0,  4'd6,1'b0,1'b0,1'b0,1'b1,1'b0,4'd6},  // R6 busy banks
        '{1'b1,1'b0,1'b1,16'd0,  4'd6,1'b0,1'b0,1'b1,1'b0,1'b0,4'd6},  // R6 entry strobe
        '{1'b1,1'b0,1'b1,16'd1,  4'd0,1'b0,1'b0,1'b0,1'b0,1'b0,4'd6},  // R6 debt cleared
        '{1'b1,1'b1,1'b1,16'd40, 4'd0,1'b0,1'b0,1'b0,1'b0,1'b0,4'd7},  // R7 asleep
        '{1'b1,1'b0,1'b0,16'd1,  4'd1,1'b0,1'b0,1'b0,1'b1,1'b1,4'd8},  // R8 wake cycle
        '{1'b1,1'b0,1'b0,16'd1,  4'd1,1'b1,1'b0,1'b0,1'b1,1'b1,4'd9},  // R9 catch-up req
        '{1'b1,1'b1,1'b0,16'd1,  4'd0,1'b0,1'b0,1'b0,1'b1,1'b0,4'd9},  // R9 back to run
        '{1'b0,1'b0,1'b0,16'd14, 4'd1,1'b0,1'b0,1'b0,1'b1,1'b0,4'd7},  // R7 restart edge236
        '{1'b1,1'b0,1'b0,16'd15, 4'd1,1'b1,1'b0,1'b0,1'b1,1'b0,4'd5},  // R5
        '{1'b1,1'b1,1'b0,16'd1,  4'd1,1'b1,1'b0,1'b0,1'b1,1'b0,4'd4},  // R4 slot+ack
        '{1'b1,1'b1,1'b0,16'd1,  4'd0,1'b0,1'b0,1'b0,1'b1,1'b0,4'd2}   // R2
    };

    int applied = 0;
    int miscompares = 0;
    bit finished = 1'b0;

    task automatic compare(input vec_t e, input string tag);
        applied++;
        if (owed_cnt !== e.owed || rf_req !== e.req || rf_urgent !== e.urg ||
            sr_entry !== e.sre || cke !== e.cke || traffic_hold !== e.hold) begin
            miscompares++;
            $display("FAIL R%0d %s: owed/req/urg/sre/cke/hold got %0d %b %b %b %b %b exp %0d %b %b %b %b %b",
                     e.rq, tag, owed_cnt, rf_req, rf_urgent, sr_entry, cke, traffic_hold,
                     e.owed, e.req, e.urg, e.sre, e.cke, e.hold);
        end
    endtask

    task automatic step(input int n);
        for (int k = 0; k < n; k++) begin
            @(posedge clk);
            #1 rf_ack = 1'b0;
        end
        @(negedge clk);
    endtask

    function automatic vec_t mk(input logic [3:0] o, input logic q, input logic u,
                                input logic s, input logic c, input logic h,
                                input logic [3:0] r);
        vec_t v;
        v = '0;
        v.owed = o; v.req = q; v.urg = u; v.sre = s; v.cke = c; v.hold = h; v.rq = r;
        return v;
    endfunction

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        compare(mk(4'd0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 4'd10), "reset state"); // R10
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            banks_idle = VEC[i].idle;
            lp_req     = VEC[i].lp;
            rf_ack     = VEC[i].ack;
            if (VEC[i].n == 16'd0) #1;
            else step(int'(VEC[i].n));
            compare(VEC[i], $sformatf("vector %0d", i));
        end

        // R10: reset taken while asleep
        banks_idle = 1'b1; lp_req = 1'b1;
        step(3);
        rst = 1'b1; lp_req = 1'b0;
        step(1);
        compare(mk(4'd0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 4'd10), "reset from self refresh");
        rst = 1'b0;

        // R9: low-power request ignored during catch-up phase
        lp_req = 1'b1;
        step(1);              // into self refresh
        lp_req = 1'b0;
        step(2);              // wake, then catch-up phase
        lp_req = 1'b1;
        #1;
        compare(mk(4'd1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 4'd9), "lp ignored in catch-up");
        rf_ack = 1'b1;
        step(1);
        // R6: back in normal mode, request still high -> immediate entry strobe
        compare(mk(4'd0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 4'd6), "re-entry after catch-up");
        lp_req = 1'b0;
        step(1);

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", applied, miscompares);
        $finish;
    end

    initial begin
        #(150000 * 5);
        if (!finished) begin
            miscompares++;
            $display("FAIL watchdog: run did not complete, got hang exp finish");
            $display("== %0d vectors applied, %0d miscompares ==", applied, miscompares);
            $finish;
        end
    end

endmodule